// File: doc/BRIEF.md
# Ready-Latency Transmit Stream Adapter

This block joins a packet source that uses a same-cycle valid/ready handshake to a transmit port whose ready signal works with a fixed latency. When that port raises its ready in cycle n, cycle n + READY_LAT is the only cycle in which a beat may be presented. The adapter queues incoming beats in a small FIFO and releases one beat in each granted cycle. Its downstream valid, start, end and data outputs all come straight from registers.

Every packet is checked before any of its beats leaves the block. The adapter works out from the packet header how many beats the packet must occupy and counts the beats that actually arrive. A packet whose count disagrees is discarded in full and a sticky error flag is raised, so the downstream port never sees a packet that would stall it. For a short time after reset the block accepts nothing and sends nothing, even when the downstream ready is already high during reset.

Top module: `rl_tx_adapter`

## Requirements
- R1: `ds_valid` is high in a cycle only if `ds_ready` was high exactly READY_LAT cycles earlier.
- R2: While `rst` is high, `ds_valid`, `up_ready` and `len_err` are low, whatever `ds_ready` does. In the first HOLD_CYC cycles after `rst` falls, `up_ready` and `ds_valid` stay low. `up_ready` may rise in the cycle after that.
- R3: The beats of accepted, well-formed packets leave in arrival order. Their data and their start and end markers are unchanged, and no beat is lost or repeated.
- R4: The first beat carries header dword 0 in bits [31:0]. Bit 30 of that dword means the packet has data, bit 29 selects a 4-dword header, bits [28:24] hold the type, and bits [9:0] hold the dword length, where 0 means 1024. The address dword is dword 3 for a 4-dword header and dword 2 for a 3-dword header. A packet with data carries one pad dword after the header when bit 2 of the address dword equals the 4-dword flag. The required beat count is the sum of header dwords, pad and data dwords, divided by DATA_W/32 and rounded up.
- R5: A type field whose bits [28:27] are 2'b10 marks a message. A message is sized as a 4-dword-header packet, even when bit 29 is clear.
- R6: A packet whose beat count differs from R4, either short or long, is dropped whole. Packets before and after it are delivered intact.
- R7: `len_err` rises when a packet is dropped and stays high until `rst`.
- R8: When the FIFO is full, `up_ready` is low. Beats held back by a stalled downstream side are delivered later without loss.
- R9: A beat that arrives outside a packet (no start marker, no open packet) is discarded and sets `len_err`. A start marker that arrives while a packet is still open abandons the open packet, which is never sent, and sets `len_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Source offers a beat |
| up_ready | output | 1 | Adapter takes the offered beat in this cycle |
| up_data | input | DATA_W | Source beat data |
| up_sop | input | 1 | First beat of a packet |
| up_eop | input | 1 | Last beat of a packet |
| ds_ready | input | 1 | Grant from the transmit port, effective READY_LAT cycles later |
| ds_valid | output | 1 | Registered beat valid in a granted cycle |
| ds_data | output | DATA_W | Registered beat data |
| ds_sop | output | 1 | Registered first-beat marker |
| ds_eop | output | 1 | Registered last-beat marker |
| len_err | output | 1 | Sticky flag: a packet or beat was dropped |

## Verification
The bench builds the adapter with a 64-bit path, a ready latency of 2, a hold-off of 2 cycles and a 32-beat FIFO. On a 64-bit path the address dword falls in the second beat and the pad dword changes the beat count, so every branch of the length rule is exercised, including the message case. The latency-2 grant pipe, the FIFO filling under a long stall, and both short and long malformed packets can all be reached with these values. The 128-bit path and a latency of 1 need the bench's two localparams changed.

// File: rtl/rl_tx_adapter.sv
module rl_tx_adapter #(
  parameter int DATA_W    = 64,
  parameter int READY_LAT = 2,
  parameter int HOLD_CYC  = 2,
  parameter int FIFO_AW   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_sop,
  input  logic              up_eop,
  input  logic              ds_ready,
  output logic              ds_valid,
  output logic [DATA_W-1:0] ds_data,
  output logic              ds_sop,
  output logic              ds_eop,
  output logic              len_err
);
  localparam int DPB   = DATA_W / 32;
  localparam int LDPB  = $clog2(DPB);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int HW    = $clog2(HOLD_CYC + 1);
  localparam int PW    = $clog2(DATA_W);
  localparam int CW    = 12;
  localparam int EW    = DATA_W + 2;

  // post-reset hold-off
  logic [HW-1:0] hold_cnt;
  logic          hold;
  assign hold = hold_cnt != '0;
  always_ff @(posedge clk)
    if (rst)       hold_cnt <= HW'(HOLD_CYC);
    else if (hold) hold_cnt <= hold_cnt - 1'b1;

  // grant pipe: gate is high in the cycle before a granted cycle
  logic gate;
  if (READY_LAT == 1) begin : g_lat1
    assign gate = ds_ready;
  end else begin : g_latn
    logic [READY_LAT-2:0] pipe;
    logic [READY_LAT-1:0] line;
    assign line = {pipe, ds_ready};
    always_ff @(posedge clk)
      if (rst) pipe <= '0;
      else     pipe <= line[READY_LAT-2:0];
    assign gate = line[READY_LAT-1];
  end

  logic [EW-1:0]    mem [DEPTH];
  logic [FIFO_AW:0] wptr, cptr, rptr;

  assign up_ready = !hold && ((wptr - rptr) != (FIFO_AW+1)'(DEPTH));

  // header tracking and beat-count check
  logic          in_pkt, drop, f4_q, hd_q, a2_q;
  logic [9:0]    ln_q;
  logic [CW-1:0] cnt_q;

  logic          acc, f4, hd, a2, pad, live, bad, stray, restart, store;
  logic [9:0]    ln;
  logic [1:0]    adw;
  logic [CW-1:0] idx, a_beat, ndw, lnx, exp_beats;
  logic [PW-1:0] apos;
  logic [FIFO_AW:0] waddr;

  assign acc     = up_valid && up_ready;
  assign idx     = up_sop ? '0 : cnt_q;
  assign f4      = up_sop ? (up_data[29] || up_data[28:27] == 2'b10) : f4_q;
  assign hd      = up_sop ? up_data[30] : hd_q;
  assign ln      = up_sop ? up_data[9:0] : ln_q;
  assign adw     = f4 ? 2'd3 : 2'd2;
  assign a_beat  = CW'(adw >> LDPB);
  assign apos    = PW'(32 * (int'(adw) % DPB) + 2);
  assign a2      = (idx == a_beat) ? up_data[apos] : a2_q;
  assign pad     = hd && (a2 == f4);
  assign lnx     = (ln == 10'd0) ? 12'd1024 : {2'b00, ln};
  assign ndw     = (f4 ? 12'd4 : 12'd3) + (hd ? lnx + {11'd0, pad} : 12'd0);
  assign exp_beats = (ndw + CW'(DPB - 1)) >> LDPB;

  assign live    = up_sop || (in_pkt && !drop);
  assign bad     = live && (up_eop ? (idx + 1'b1 != exp_beats)
                                   : (idx >= a_beat && idx + 1'b1 >= exp_beats));
  assign stray   = !up_sop && !in_pkt;
  assign restart = up_sop && in_pkt && !drop;
  assign store   = acc && live && !bad;
  assign waddr   = up_sop ? cptr : wptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; cptr <= '0; in_pkt <= 1'b0; drop <= 1'b0; len_err <= 1'b0;
      cnt_q <= '0; f4_q <= 1'b0; hd_q <= 1'b0; ln_q <= '0; a2_q <= 1'b0;
    end else if (acc) begin
      if (up_sop) begin f4_q <= f4; hd_q <= hd; ln_q <= ln; end
      if (idx == a_beat) a2_q <= up_data[apos];
      cnt_q  <= idx + 1'b1;
      in_pkt <= (up_sop || in_pkt) && !up_eop;
      drop   <= (bad || (drop && !up_sop)) && !up_eop;
      if (stray || restart || bad) len_err <= 1'b1;
      if (bad) wptr <= cptr;
      else if (store) wptr <= waddr + 1'b1;
      if (store && up_eop) cptr <= waddr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (store) mem[waddr[FIFO_AW-1:0]] <= {up_sop, up_eop, up_data};

  // read side: only committed beats, only in granted cycles
  logic rd_ok;
  assign rd_ok = gate && !hold && (rptr != cptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr <= '0; ds_valid <= 1'b0; ds_sop <= 1'b0; ds_eop <= 1'b0; ds_data <= '0;
    end else begin
      ds_valid <= rd_ok;
      if (rd_ok) begin
        {ds_sop, ds_eop, ds_data} <= mem[rptr[FIFO_AW-1:0]];
        rptr <= rptr + 1'b1;
      end
    end
  end

  assert_grant_slot_R1: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> $past(ds_ready, READY_LAT));

  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) |-> !ds_valid);

  assert_commit_order_R6: assert property (@(posedge clk) disable iff (rst)
    (cptr - rptr) <= (wptr - rptr));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(len_err) |-> len_err);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) <= (FIFO_AW+1)'(DEPTH));
endmodule

// File: tb/test_rl_tx_adapter.sv
module test_rl_tx_adapter;
  localparam int DW  = 64;
  localparam int RL  = 2;
  localparam int DPB = DW / 32;

  logic clk = 1'b0, rst = 1'b1;
  logic up_valid, up_ready, up_sop, up_eop, ds_ready = 1'b1, ds_valid, ds_sop, ds_eop, len_err;
  logic [DW-1:0] up_data, ds_data;

  always #4 clk = ~clk;

  rl_tx_adapter #(.DATA_W(DW), .READY_LAT(RL)) i_rl_tx_adapter (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .up_sop(up_sop), .up_eop(up_eop), .ds_ready(ds_ready), .ds_valid(ds_valid),
    .ds_data(ds_data), .ds_sop(ds_sop), .ds_eop(ds_eop), .len_err(len_err));

  int checks = 0, errors = 0, tagc = 1, rmode = 1;
  bit busy = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [RL:0] rhist = '0;
  logic [DW+1:0] expq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW+1:0] act, input logic [DW+1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: ds_ready <= 1'b0;
      1: ds_ready <= 1'b1;
      2: ds_ready <= ~ds_ready;
      default: ds_ready <= lfsr[0];
    endcase
  end

  always @(posedge clk) rhist <= {rhist[RL-1:0], ds_ready};

  // monitor: grant rule and scoreboard
  always @(negedge clk) begin
    logic [DW+1:0] e;
    if (!rst && ds_valid) begin
      check(rhist[RL-1], "R1", "valid without grant", {{DW+1{1'b0}}, rhist[RL-1]}, 1);
      if (expq.size() == 0)
        check(0, "R6", "unexpected beat", {ds_sop, ds_eop, ds_data}, 0);
      else begin
        e = expq.pop_front();
        check({ds_sop, ds_eop, ds_data} === e, "R3", "beat", {ds_sop, ds_eop, ds_data}, e);
      end
    end
  end

  task automatic drive_beat(input logic [DW+1:0] b);
    @(negedge clk);
    up_valid = 1'b1;
    {up_sop, up_eop, up_data} = b;
    #1;
    while (!up_ready) begin @(negedge clk); #1; end
  endtask

  task automatic send_pkt(input bit f4, input bit hd, input logic [4:0] typ, input int len,
                          input bit a2, input int delta, input bit noeop, input bit good);
    logic [31:0] dws[$];
    logic [DW+1:0] beats[$];
    logic [DW-1:0] d;
    bit e4;
    int nb;
    e4 = f4 || (typ[4:3] == 2'b10);
    dws.push_back({1'b0, hd, f4, typ, 14'h0, 10'(len)});
    dws.push_back(32'h0100_0000 + tagc);
    if (e4) begin
      dws.push_back(32'h0000_0004 | (tagc << 8));
      dws.push_back({29'(tagc), a2, 2'b00});
    end else
      dws.push_back({29'(tagc + 7), a2, 2'b00});
    if (hd && (a2 == e4)) dws.push_back(32'hDEAD_0000);
    if (hd) for (int i = 0; i < len; i++) dws.push_back({tagc[15:0], 16'(i)});
    nb = (dws.size() + DPB - 1) / DPB + delta;
    for (int b = 0; b < nb; b++) begin
      for (int l = 0; l < DPB; l++)
        d[l*32 +: 32] = (b*DPB + l < dws.size()) ? dws[b*DPB + l] : 32'hF00D_0000 + b;
      beats.push_back({b == 0, (b == nb - 1) && !noeop, d});
    end
    if (good) foreach (beats[i]) expq.push_back(beats[i]);
    tagc++;
    foreach (beats[i]) drive_beat(beats[i]);
    @(negedge clk);
    up_valid = 1'b0; up_sop = 1'b0; up_eop = 1'b0;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (expq.size() != 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
    check(expq.size() == 0, req, "beats left undelivered", expq.size(), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    up_valid = 0; up_sop = 0; up_eop = 0; up_data = '0;
    repeat (3) @(negedge clk);
    check(!ds_valid && !up_ready && !len_err, "R2", "quiet during reset with ready high",
          {ds_valid, up_ready, len_err}, 0);
    rst = 1'b0; #1;
    check(!up_ready && !ds_valid, "R2", "hold cycle 1", {up_ready, ds_valid}, 0);
    @(negedge clk); #1;
    check(!up_ready && !ds_valid, "R2", "hold cycle 2", {up_ready, ds_valid}, 0);
    @(negedge clk); #1;
    check(up_ready, "R2", "ready after hold", up_ready, 1);

    // R4: length rule, with and without pad, both header sizes
    send_pkt(0, 0, 5'h00, 0, 0, 0, 0, 1);
    send_pkt(0, 1, 5'h00, 1, 0, 0, 0, 1);
    send_pkt(0, 1, 5'h00, 3, 1, 0, 0, 1);
    send_pkt(1, 1, 5'h00, 2, 0, 0, 0, 1);
    send_pkt(1, 1, 5'h00, 1, 1, 0, 0, 1);
    send_pkt(0, 1, 5'h00, 9, 0, 0, 0, 1);
    send_pkt(1, 0, 5'h00, 0, 1, 0, 0, 1);
    drain("R4");
    check(!len_err, "R4", "no error on well-formed packets", len_err, 0);

    // R5: messages sized as 4-dword headers
    send_pkt(0, 1, 5'h10, 1, 1, 0, 0, 1);
    send_pkt(0, 0, 5'h13, 0, 0, 0, 0, 1);
    drain("R5");
    check(!len_err, "R5", "message accepted", len_err, 0);

    // R1/R3: sparse and irregular grants
    rmode = 2;
    send_pkt(0, 1, 5'h00, 5, 1, 0, 0, 1);
    send_pkt(1, 1, 5'h00, 4, 0, 0, 0, 1);
    rmode = 3;
    for (int k = 0; k < 4; k++) send_pkt(k[0], 1, 5'h00, 2 + k, k[1], 0, 0, 1);
    drain("R3");
    rmode = 1;

    // R8: stall downstream until the FIFO fills
    busy = 1; rmode = 0;
    fork
      begin
        for (int k = 0; k < 6; k++) send_pkt(0, 1, 5'h00, 8, 1, 0, 0, 1);
        busy = 0;
      end
    join_none
    repeat (80) @(negedge clk);
    #1;
    check(!up_ready && up_valid, "R8", "source held off when full", {up_ready, up_valid}, 2'b01);
    rmode = 1;
    wait (busy == 0);
    drain("R8");

    // R6/R7: short and long packets dropped whole
    send_pkt(0, 1, 5'h00, 4, 1, -1, 0, 0);
    send_pkt(0, 1, 5'h00, 2, 1, 0, 0, 1);
    drain("R6");
    check(len_err, "R6", "short packet flagged", len_err, 1);
    send_pkt(1, 1, 5'h00, 2, 0, 1, 0, 0);
    send_pkt(1, 1, 5'h00, 3, 0, 0, 0, 1);
    drain("R6");
    send_pkt(0, 0, 5'h00, 0, 0, 0, 0, 1);
    drain("R7");
    check(len_err, "R7", "flag stays high", len_err, 1);
    do_reset();
    check(!len_err, "R7", "flag cleared by reset", len_err, 0);

    // R9: stray beat, then an abandoned open packet
    drive_beat({1'b0, 1'b0, {(DW/32){32'hBAD0_BAD0}}});
    @(negedge clk); up_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(len_err, "R9", "stray beat flagged", len_err, 1);
    send_pkt(0, 1, 5'h00, 4, 1, -1, 1, 0);
    send_pkt(1, 1, 5'h00, 2, 1, 0, 0, 1);
    drain("R9");

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    summary();
    $finish;
  end
endmodule